// File: doc/BRIEF.md
# Saturating Coulomb Count Accumulator

This block is the digital back end of a charge counter. An analog integrator elsewhere on the chip emits a one-cycle tick, together with a direction bit, every time its ramp reverses. The block divides these ticks by a programmable power-of-two factor M in an up/down prescaler. Every prescaler wrap then moves a 16-bit charge count by one step, up or down. At the limits the count saturates instead of wrapping.

The count is compared with a high and a low threshold. Three sticky flags record a crossing above the high threshold, a crossing below the low threshold, and a step that reaches either end of the range. A two-bit pin mode field controls two functions. One is an active-high alert output that summarises the flags. The other is a charge-complete input that presets the count to full scale. Write ports load the count, the two thresholds and a control word (scale field, pin mode, shutdown).

Top module: `charge_tally`

## Requirements
- R1: After reset the count reads 7FFFh, all three flags and the alert output are 0, the high threshold is FFFFh, the low threshold is 0000h, the scale field is 7 (M = 128), the pin mode is 10b and shutdown is off.
- R2: With scale field s, M = 2^s. Starting from a zero residue, M up ticks raise the count by exactly one, on the M-th tick. With M = 1 every up tick raises the count by one.
- R3: A down tick at zero residue sets the residue to M-1 and lowers the count by one. Further down ticks only count the residue down until it is zero again.
- R4: The count never wraps. An up step at FFFFh holds it at FFFFh and a down step at 0000h holds it at 0000h. Any counting step that leaves the count at FFFFh or 0000h sets the saturation flag in the same cycle. Reversing the direction moves the count away from the limit.
- R5: A write to the count takes effect on the next clock edge. It has priority over a charge-complete preset and over a tick in the same cycle.
- R6: The high flag is set one cycle after the count is strictly above the high threshold. The low flag is set one cycle after the count is strictly below the low threshold. Equality sets neither flag.
- R7: Pin mode bit 0 enables charge-complete. The input passes through two synchronizing flops. While it is high and bit 0 is set, the count is forced to FFFFh. With bit 0 clear the input has no effect.
- R8: While the shutdown bit is 1, ticks do not change the count. The prescaler residue is cleared to zero, so after shutdown ends a full M up ticks are needed for the next step.
- R9: Pin mode bit 1 enables the alert output. Alert is 1 when bit 1 is set and any flag is set, and 0 otherwise.
- R10: Flags stay set until a clear pulse arrives. The clear has no effect on a flag whose condition still holds: count above the high threshold, count below the low threshold, or count at FFFFh or 0000h.
- R11: A control write loads the scale field, pin mode and shutdown bit together. They take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle integrator reversal event |
| tick_up_i | input | 1 | Direction of the tick: 1 adds charge, 0 removes it |
| cc_i | input | 1 | Asynchronous charge-complete level |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_scale_i | input | 3 | Prescale exponent s, M = 2^s |
| ctl_mode_i | input | 2 | Pin mode: bit 1 alert enable, bit 0 charge-complete enable |
| ctl_shdn_i | input | 1 | Shutdown bit |
| acc_wr_i | input | 1 | Count write strobe |
| acc_wdata_i | input | 16 | Count write value |
| thr_hi_wr_i | input | 1 | High threshold write strobe |
| thr_lo_wr_i | input | 1 | Low threshold write strobe |
| thr_wdata_i | input | 16 | Threshold write value |
| flag_clr_i | input | 1 | Flag clear pulse |
| acc_o | output | 16 | Current charge count |
| flag_hi_o | output | 1 | High threshold flag |
| flag_lo_o | output | 1 | Low threshold flag |
| flag_sat_o | output | 1 | Saturation flag |
| alert_o | output | 1 | Active-high alert |

## Verification
The checker watches several rules on every cycle. The count must never jump from one end of the range to the other without a write or a preset. A write must land one cycle later, and a preset must yield FFFFh. In shutdown the count must hold still, and each threshold flag may rise only after the count was past its threshold. The scenarios show what a single-cycle property cannot. These are the prescaler division for a given M and the residue it keeps between steps, and the loss of that residue in shutdown. They also cover the clear that is refused while a condition persists, and the synchronizer latency on the charge-complete input.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  localparam int CTL_SCALE_W = 3;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  typedef struct packed {
    logic [CTL_SCALE_W-1:0] scale;
    logic                   alert_en;
    logic                   cc_en;
    logic                   shdn;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{scale: '1, alert_en: 1'b1, cc_en: 1'b0, shdn: 1'b0};

endpackage

// File: rtl/ctr_sync.sv
module ctr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ctr_prescale.sv
module ctr_prescale
  import ctr_pkg::*;
#(
  parameter int SCALE_W = CTL_SCALE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               up_i,
  input  logic               shdn_i,
  input  logic [SCALE_W-1:0] scale_i,
  output step_e              step_o
);

  localparam int RES_W = (1 << SCALE_W) - 1;

  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] res_d;
  logic [RES_W:0]   m_full;
  logic [RES_W-1:0] m_top;
  step_e            step;

  always_comb begin
    m_full = (RES_W+1)'(1) << scale_i;
    m_top  = RES_W'(m_full - 1'b1);
  end

  always_comb begin
    res_d = res_q;
    step  = STEP_NONE;
    if (shdn_i) begin
      res_d = '0;
    end else if (tick_i) begin
      if (up_i) begin
        if (res_q >= m_top) begin
          res_d = '0;
          step  = STEP_INC;
        end else begin
          res_d = res_q + 1'b1;
        end
      end else begin
        if (res_q == '0) begin
          res_d = m_top;
          step  = STEP_DEC;
        end else begin
          res_d = res_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign step_o = step;

endmodule

// File: rtl/ctr_acc.sv
module ctr_acc
  import ctr_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step_i,
  input  logic             wr_i,
  input  logic [ACC_W-1:0] wdata_i,
  input  logic             preset_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             sat_evt_o
);

  localparam logic [ACC_W-1:0] FULL    = '1;
  localparam logic [ACC_W-1:0] EMPTY   = '0;
  localparam logic [ACC_W-1:0] RST_VAL = {1'b0, {(ACC_W-1){1'b1}}};

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             sat_evt;

  always_comb begin
    acc_d   = acc_q;
    sat_evt = 1'b0;
    if (wr_i) begin
      acc_d = wdata_i;
    end else if (preset_i) begin
      acc_d = FULL;
    end else begin
      unique case (step_i)
        STEP_INC: begin
          if (acc_q != FULL) acc_d = acc_q + 1'b1;
          sat_evt = (acc_d == FULL);
        end
        STEP_DEC: begin
          if (acc_q != EMPTY) acc_d = acc_q - 1'b1;
          sat_evt = (acc_d == EMPTY);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= RST_VAL;
    else        acc_q <= acc_d;
  end

  assign acc_o     = acc_q;
  assign sat_evt_o = sat_evt;

endmodule

// File: rtl/ctr_monitor.sv
module ctr_monitor #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             sat_evt_i,
  input  logic             hi_wr_i,
  input  logic             lo_wr_i,
  input  logic [ACC_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] thr_hi_o,
  output logic [ACC_W-1:0] thr_lo_o,
  output logic             flag_hi_o,
  output logic             flag_lo_o,
  output logic             flag_sat_o
);

  logic [ACC_W-1:0] thr_hi_q;
  logic [ACC_W-1:0] thr_lo_q;
  logic             hi_q, lo_q, sat_q;
  logic             hi_d, lo_d, sat_d;
  logic             hi_cond, lo_cond, lim_cond;

  always_comb begin
    hi_cond  = (acc_i > thr_hi_q);
    lo_cond  = (acc_i < thr_lo_q);
    lim_cond = (acc_i == '1) || (acc_i == '0);
    hi_d     = hi_cond  | (hi_q  & ~clr_i);
    lo_d     = lo_cond  | (lo_q  & ~clr_i);
    sat_d    = sat_evt_i | (sat_q & ~(clr_i & ~lim_cond));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_hi_q <= '1;
    else if (hi_wr_i) thr_hi_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_lo_q <= '0;
    else if (lo_wr_i) thr_lo_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      sat_q <= sat_d;
    end
  end

  assign thr_hi_o   = thr_hi_q;
  assign thr_lo_o   = thr_lo_q;
  assign flag_hi_o  = hi_q;
  assign flag_lo_o  = lo_q;
  assign flag_sat_o = sat_q;

endmodule

// File: rtl/charge_tally.sv
module charge_tally
  import ctr_pkg::*;
#(
  parameter int ACC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   tick_up_i,
  input  logic                   cc_i,
  input  logic                   ctl_wr_i,
  input  logic [CTL_SCALE_W-1:0] ctl_scale_i,
  input  logic [1:0]             ctl_mode_i,
  input  logic                   ctl_shdn_i,
  input  logic                   acc_wr_i,
  input  logic [ACC_W-1:0]       acc_wdata_i,
  input  logic                   thr_hi_wr_i,
  input  logic                   thr_lo_wr_i,
  input  logic [ACC_W-1:0]       thr_wdata_i,
  input  logic                   flag_clr_i,
  output logic [ACC_W-1:0]       acc_o,
  output logic                   flag_hi_o,
  output logic                   flag_lo_o,
  output logic                   flag_sat_o,
  output logic                   alert_o
);

  ctl_t             ctl_q;
  ctl_t             ctl_d;
  logic             cc_sync;
  logic             cc_hit;
  step_e            step;
  logic             sat_evt;
  logic [ACC_W-1:0] thr_hi;
  logic [ACC_W-1:0] thr_lo;

  always_comb begin
    ctl_d.scale    = ctl_scale_i;
    ctl_d.alert_en = ctl_mode_i[1];
    ctl_d.cc_en    = ctl_mode_i[0];
    ctl_d.shdn     = ctl_shdn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else if (ctl_wr_i) ctl_q <= ctl_d;
  end

  ctr_sync #(.STAGES(SYNC_STAGES)) u_cc_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cc_i),
    .q_o   (cc_sync)
  );

  assign cc_hit = cc_sync & ctl_q.cc_en;

  ctr_prescale #(.SCALE_W(CTL_SCALE_W)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .up_i    (tick_up_i),
    .shdn_i  (ctl_q.shdn),
    .scale_i (ctl_q.scale),
    .step_o  (step)
  );

  ctr_acc #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .wr_i      (acc_wr_i),
    .wdata_i   (acc_wdata_i),
    .preset_i  (cc_hit),
    .acc_o     (acc_o),
    .sat_evt_o (sat_evt)
  );

  ctr_monitor #(.ACC_W(ACC_W)) u_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_i      (acc_o),
    .sat_evt_i  (sat_evt),
    .hi_wr_i    (thr_hi_wr_i),
    .lo_wr_i    (thr_lo_wr_i),
    .wdata_i    (thr_wdata_i),
    .clr_i      (flag_clr_i),
    .thr_hi_o   (thr_hi),
    .thr_lo_o   (thr_lo),
    .flag_hi_o  (flag_hi_o),
    .flag_lo_o  (flag_lo_o),
    .flag_sat_o (flag_sat_o)
  );

  assign alert_o = ctl_q.alert_en & (flag_hi_o | flag_lo_o | flag_sat_o);

endmodule

// File: rtl/charge_tally_chk.sv
module charge_tally_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] acc_o,
  input logic             acc_wr_i,
  input logic [ACC_W-1:0] acc_wdata_i,
  input logic             cc_hit,
  input logic             shdn,
  input logic             flag_hi_o,
  input logic             flag_lo_o,
  input logic [ACC_W-1:0] thr_hi,
  input logic [ACC_W-1:0] thr_lo
);

  // R4
  top_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o == '1 && !acc_wr_i && !cc_hit) |=> (acc_o != '0));

  // R4
  bottom_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o == '0 && !acc_wr_i && !cc_hit) |=> (acc_o != '1));

  // R5
  host_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr_i |=> (acc_o == $past(acc_wdata_i)));

  // R7
  preset_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_hit && !acc_wr_i) |=> (acc_o == '1));

  // R8
  shutdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn && !acc_wr_i && !cc_hit) |=> $stable(acc_o));

  // R6
  hi_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_hi_o) |-> ($past(acc_o) > $past(thr_hi)));

  // R6
  lo_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_lo_o) |-> ($past(acc_o) < $past(thr_lo)));

endmodule

bind charge_tally charge_tally_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_o       (acc_o),
  .acc_wr_i    (acc_wr_i),
  .acc_wdata_i (acc_wdata_i),
  .cc_hit      (cc_hit),
  .shdn        (ctl_q.shdn),
  .flag_hi_o   (flag_hi_o),
  .flag_lo_o   (flag_lo_o),
  .thr_hi      (thr_hi),
  .thr_lo      (thr_lo)
);

// File: tb/charge_tally_test.sv
module charge_tally_test;

  logic        clk;
  logic        rst_n;
  logic        tick_i, tick_up_i, cc_i;
  logic        ctl_wr_i, ctl_shdn_i;
  logic [2:0]  ctl_scale_i;
  logic [1:0]  ctl_mode_i;
  logic        acc_wr_i;
  logic [15:0] acc_wdata_i;
  logic        thr_hi_wr_i, thr_lo_wr_i;
  logic [15:0] thr_wdata_i;
  logic        flag_clr_i;
  logic [15:0] acc_o;
  logic        flag_hi_o, flag_lo_o, flag_sat_o, alert_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  charge_tally uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .tick_up_i   (tick_up_i),
    .cc_i        (cc_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_scale_i (ctl_scale_i),
    .ctl_mode_i  (ctl_mode_i),
    .ctl_shdn_i  (ctl_shdn_i),
    .acc_wr_i    (acc_wr_i),
    .acc_wdata_i (acc_wdata_i),
    .thr_hi_wr_i (thr_hi_wr_i),
    .thr_lo_wr_i (thr_lo_wr_i),
    .thr_wdata_i (thr_wdata_i),
    .flag_clr_i  (flag_clr_i),
    .acc_o       (acc_o),
    .flag_hi_o   (flag_hi_o),
    .flag_lo_o   (flag_lo_o),
    .flag_sat_o  (flag_sat_o),
    .alert_o     (alert_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input logic up, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1; tick_up_i = up;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic ctl(input logic [2:0] s, input logic [1:0] m, input logic sd);
    @(negedge clk);
    ctl_wr_i = 1'b1; ctl_scale_i = s; ctl_mode_i = m; ctl_shdn_i = sd;
    @(negedge clk);
    ctl_wr_i = 1'b0;
  endtask

  task automatic wr_acc(input logic [15:0] v);
    @(negedge clk);
    acc_wr_i = 1'b1; acc_wdata_i = v;
    @(negedge clk);
    acc_wr_i = 1'b0;
  endtask

  task automatic wr_thr(input logic hi, input logic [15:0] v);
    @(negedge clk);
    thr_hi_wr_i = hi; thr_lo_wr_i = ~hi; thr_wdata_i = v;
    @(negedge clk);
    thr_hi_wr_i = 1'b0; thr_lo_wr_i = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 count", acc_o, 16'h7FFF);
    check("R1 flags", {13'd0, flag_hi_o, flag_lo_o, flag_sat_o}, 16'h0);
    check("R1 alert", {15'd0, alert_o}, 16'h0);
  endtask

  task automatic test_default_scale();
    tick(1'b1, 127);
    check("R11 M=128 before last", acc_o, 16'h7FFF);
    tick(1'b1, 1);
    check("R11 M=128 step", acc_o, 16'h8000);
  endtask

  task automatic test_divide();
    ctl(3'd2, 2'b10, 1'b0);
    tick(1'b1, 3);
    check("R2 M=4 three ups", acc_o, 16'h8000);
    tick(1'b1, 1);
    check("R2 M=4 fourth up", acc_o, 16'h8001);
    tick(1'b0, 1);
    check("R3 down at zero residue", acc_o, 16'h8000);
    tick(1'b0, 3);
    check("R3 residue drains", acc_o, 16'h8000);
    tick(1'b0, 1);
    check("R3 next underflow", acc_o, 16'h7FFF);
  endtask

  task automatic test_shutdown();
    ctl(3'd2, 2'b10, 1'b1);
    tick(1'b1, 6);
    check("R8 ticks ignored", acc_o, 16'h7FFF);
    ctl(3'd2, 2'b10, 1'b0);
    tick(1'b1, 3);
    check("R8 residue cleared", acc_o, 16'h7FFF);
    tick(1'b1, 1);
    check("R8 full M after wake", acc_o, 16'h8000);
  endtask

  task automatic test_write_priority();
    ctl(3'd0, 2'b10, 1'b0);
    @(negedge clk);
    acc_wr_i = 1'b1; acc_wdata_i = 16'h1234; tick_i = 1'b1; tick_up_i = 1'b1;
    @(negedge clk);
    acc_wr_i = 1'b0; tick_i = 1'b0;
    check("R5 write beats tick", acc_o, 16'h1234);
    tick(1'b1, 1);
    check("R2 M=1 step", acc_o, 16'h1235);
  endtask

  task automatic test_saturate();
    wr_acc(16'hFFFE);
    tick(1'b1, 1);
    check("R4 reach top", acc_o, 16'hFFFF);
    check("R4 sat flag", {15'd0, flag_sat_o}, 16'h1);
    tick(1'b1, 1);
    check("R4 hold top", acc_o, 16'hFFFF);
    tick(1'b0, 1);
    check("R4 leave top", acc_o, 16'hFFFE);
    wr_acc(16'h0001);
    tick(1'b0, 2);
    check("R4 hold bottom", acc_o, 16'h0000);
    idle(1);
    check("R6 equal thresholds no flag", {14'd0, flag_hi_o, flag_lo_o}, 16'h0);
    check("R9 alert on sat", {15'd0, alert_o}, 16'h1);
  endtask

  task automatic test_clear();
    clr();
    check("R10 clear refused at limit", {15'd0, flag_sat_o}, 16'h1);
    tick(1'b1, 1);
    clr();
    check("R10 clear accepted", {15'd0, flag_sat_o}, 16'h0);
    check("R9 alert drops", {15'd0, alert_o}, 16'h0);
  endtask

  task automatic test_thresholds();
    wr_thr(1'b1, 16'h1000);
    wr_acc(16'h1000);
    idle(2);
    check("R6 hi equal", {15'd0, flag_hi_o}, 16'h0);
    tick(1'b1, 1);
    idle(1);
    check("R6 hi above", {15'd0, flag_hi_o}, 16'h1);
    check("R9 alert on hi", {15'd0, alert_o}, 16'h1);
    clr();
    check("R10 hi clear refused", {15'd0, flag_hi_o}, 16'h1);
    wr_acc(16'h0800);
    clr();
    check("R10 hi clear accepted", {15'd0, flag_hi_o}, 16'h0);
    wr_thr(1'b0, 16'h0100);
    wr_acc(16'h0100);
    idle(2);
    check("R6 lo equal", {15'd0, flag_lo_o}, 16'h0);
    tick(1'b0, 1);
    idle(1);
    check("R6 lo below", {15'd0, flag_lo_o}, 16'h1);
    ctl(3'd0, 2'b00, 1'b0);
    check("R9 alert disabled", {15'd0, alert_o}, 16'h0);
    wr_acc(16'h0500);
    clr();
    check("R10 lo cleared", {15'd0, flag_lo_o}, 16'h0);
  endtask

  task automatic test_charge_complete();
    ctl(3'd0, 2'b10, 1'b0);
    @(negedge clk);
    cc_i = 1'b1;
    idle(5);
    check("R7 ignored outside mode 01", acc_o, 16'h0500);
    cc_i = 1'b0;
    idle(3);
    ctl(3'd0, 2'b01, 1'b0);
    @(negedge clk);
    cc_i = 1'b1;
    idle(1);
    check("R7 synchronizer delay", acc_o, 16'h0500);
    idle(3);
    check("R7 preset full", acc_o, 16'hFFFF);
    cc_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    tick_i = 0; tick_up_i = 0; cc_i = 0;
    ctl_wr_i = 0; ctl_scale_i = 0; ctl_mode_i = 0; ctl_shdn_i = 0;
    acc_wr_i = 0; acc_wdata_i = 0;
    thr_hi_wr_i = 0; thr_lo_wr_i = 0; thr_wdata_i = 0;
    flag_clr_i = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    test_reset();
    test_default_scale();
    test_divide();
    test_shutdown();
    test_write_priority();
    test_saturate();
    test_clear();
    test_thresholds();
    test_charge_complete();
    idle(2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule